// File: doc/BRIEF.md
# UART transmit protocol checker

This block is a synthesizable monitor placed beside a UART transmitter. It drives nothing on the transmitter. Every clock it samples the transmitter's start request, busy flag, serial line and the valid/ready handshake. When the transmitter breaks its timing contract, the monitor reports it.

Each kind of violation has a bit in a six-bit error vector. A bit gives a one-cycle pulse on `err_pulse` and stays latched in `err_sticky` until reset. The monitor also measures how many low cycles the start bit lasted and exposes the count on `start_len`. A wrong start-bit length can therefore be read as a number, not only as a flag. The bit period is set by `BIT_CLKS`, the data width by `DATA_BITS`, and the longest accepted handshake latency by `HS_WIN`.

The frame checker is a state machine with five states:

| State | Meaning | Leaves to |
|---|---|---|
| FR_IDLE | Waiting for a frame | FR_START on a busy rise |
| FR_START | Start bit, one period | FR_IDLE if the line goes high early; FR_DATA after a full low period |
| FR_DATA | Data bits, one period each | FR_STOP after the last bit |
| FR_STOP | Stop bit, one period | FR_IDLE if the line goes low; FR_GAP after a full high period |
| FR_GAP | One cycle | FR_IDLE always |

The handshake checker has two states. HS_IDLE moves to HS_WAIT on a rise of valid. HS_WAIT returns to HS_IDLE when ready arrives or when the window expires.

Top module: `uart_tx_monitor`

## Requirements
- R1: A busy rise begins a frame. The start bit occupies the `BIT_CLKS` cycles that follow the busy rise. A start bit that is low for exactly that long raises no error, and `start_len` then reads `BIT_CLKS`.
- R2: If the line returns high after L < `BIT_CLKS` low cycles, error bit 0 pulses and `start_len` reads L. The frame is then abandoned.
- R3: If the low run ends at a length L with `BIT_CLKS` < L < 2·`BIT_CLKS`, error bit 0 pulses and `start_len` reads L.
- R4: When `tx_start` rises, `tx_busy` must be high in the next cycle. Otherwise error bit 1 pulses.
- R5: After a rise of `tx_valid`, `tx_ready` is accepted from 1 to `HS_WIN` cycles later. If `tx_ready` has not been seen by `HS_WIN` cycles, error bit 2 pulses.
- R6: Inside a data-bit period the line may only change on the period's first cycle. Any later change pulses error bit 4, once for each change.
- R7: The line must stay high for the whole stop-bit period. A low cycle there pulses error bit 3 and abandons the frame.
- R8: In the cycle right after the stop bit, busy must be low. If busy is high, error bit 5 pulses.
- R9: Each violation gives a single-cycle pulse on `err_pulse`, in the cycle after the sampled cycle that broke the rule. The same edge sets the matching `err_sticky` bit, which holds until reset. Two violations decided in the same cycle pulse together.
- R10: While `rst` is high, all outputs read zero, no check runs, and any frame or handshake in progress is dropped.
- R11: The start-bit low count saturates at 2·`BIT_CLKS`. A line held low through the start and the following data bits reads 2·`BIT_CLKS` and raises no start error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Transmitter data-valid |
| tx_ready | input | 1 | Transmitter ready response |
| tx_start | input | 1 | Transmit start request |
| tx_busy | input | 1 | Transmitter busy flag |
| tx_line | input | 1 | Serial output line, idle high |
| err_pulse | output | 6 | One-cycle violation pulses: bit 0 start length, 1 busy response, 2 handshake timeout, 3 stop level, 4 data stability, 5 frame gap |
| err_sticky | output | 6 | Latched violations, same bit order, cleared by reset |
| start_len | output | LEN_W | Last measured start-bit low count |

## Verification
A start bit that runs past its period and ends inside the first data bit breaks two rules on one line change. It gives the wrong start length, and it changes the line inside a data bit. The bench drives a start bit of `BIT_CLKS`+1 low cycles with a first data bit of one. It expects a single pulse cycle that carries both bit 0 and bit 4, with `start_len` reading `BIT_CLKS`+1. The scoreboard then expects no further pulse from the rest of that frame.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

    localparam int ERR_N  = 6;
    localparam int E_START = 0;
    localparam int E_BUSY  = 1;
    localparam int E_HSHK  = 2;
    localparam int E_STOP  = 3;
    localparam int E_DATA  = 4;
    localparam int E_GAP   = 5;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP,
        FR_GAP
    } frame_st_e;

    typedef enum logic {
        HS_IDLE,
        HS_WAIT
    } hs_st_e;

endpackage

// File: rtl/uart_mon_busy.sv
module uart_mon_busy (
    input  logic clk,
    input  logic rst,
    input  logic tx_start,
    input  logic tx_busy,
    output logic viol
);
    logic start_q;
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            start_q <= tx_start;
            pend    <= tx_start && !start_q;
        end
    end

    // a start rise one cycle ago must see busy now
    assign viol = pend && !tx_busy;

endmodule

// File: rtl/uart_mon_hshk.sv
module uart_mon_hshk
    import uart_mon_pkg::*;
#(
    parameter int WIN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic tx_ready,
    output logic viol
);
    localparam int CNT_W = $clog2(WIN + 1);

    hs_st_e           st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= HS_IDLE;
            cnt     <= '0;
            valid_q <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            valid_q <= tx_valid;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        viol  = 1'b0;
        unique case (st)
            HS_IDLE: begin
                if (tx_valid && !valid_q) begin
                    st_n  = HS_WAIT;
                    cnt_n = CNT_W'(1);
                end
            end
            HS_WAIT: begin
                if (tx_ready) begin
                    st_n = HS_IDLE;
                end else if (cnt == CNT_W'(WIN)) begin
                    viol = 1'b1;
                    st_n = HS_IDLE;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            default: st_n = HS_IDLE;
        endcase
    end

    // R5: the wait count stays inside the accepted window
    a_r5_wait_in_window: assert property (@(posedge clk) disable iff (rst)
        (st == HS_WAIT) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(WIN)));

endmodule

// File: rtl/uart_mon_frame.sv
module uart_mon_frame
    import uart_mon_pkg::*;
#(
    parameter int BIT_CLKS  = 217,
    parameter int DATA_BITS = 8,
    parameter int LEN_W     = $clog2(2 * BIT_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_busy,
    input  logic             tx_line,
    output logic             v_start,
    output logic             v_data,
    output logic             v_stop,
    output logic             v_gap,
    output logic [LEN_W-1:0] meas_len
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0]    CYC_LAST = CW'(BIT_CLKS - 1);
    localparam logic [BW-1:0]    BIT_LAST = BW'(DATA_BITS - 1);
    localparam logic [LEN_W-1:0] LEN_OK   = LEN_W'(BIT_CLKS);
    localparam logic [LEN_W-1:0] LEN_SAT  = LEN_W'(2 * BIT_CLKS);

    frame_st_e     st, st_n;
    logic [CW-1:0] cyc, cyc_n;
    logic [BW-1:0] bit_idx, bit_n;
    logic          lvl, lvl_n;
    logic          busy_q;
    logic          busy_rise;

    logic             run_live;
    logic [LEN_W-1:0] low_run;

    assign busy_rise = tx_busy && !busy_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FR_IDLE;
            cyc     <= '0;
            bit_idx <= '0;
            lvl     <= 1'b1;
            busy_q  <= 1'b0;
        end else begin
            st      <= st_n;
            cyc     <= cyc_n;
            bit_idx <= bit_n;
            lvl     <= lvl_n;
            busy_q  <= tx_busy;
        end
    end

    // next state and violation outputs
    always_comb begin
        st_n   = st;
        cyc_n  = cyc;
        bit_n  = bit_idx;
        lvl_n  = lvl;
        v_data = 1'b0;
        v_stop = 1'b0;
        v_gap  = 1'b0;
        unique case (st)
            FR_IDLE: begin
                if (busy_rise) begin
                    st_n  = FR_START;
                    cyc_n = '0;
                end
            end
            FR_START: begin
                if (tx_line) begin
                    st_n = FR_IDLE;
                end else if (cyc == CYC_LAST) begin
                    st_n  = FR_DATA;
                    cyc_n = '0;
                    bit_n = '0;
                end else begin
                    cyc_n = cyc + CW'(1);
                end
            end
            FR_DATA: begin
                lvl_n = tx_line;
                if (cyc != '0 && tx_line != lvl) v_data = 1'b1;
                if (cyc == CYC_LAST) begin
                    cyc_n = '0;
                    if (bit_idx == BIT_LAST) st_n = FR_STOP;
                    else                     bit_n = bit_idx + BW'(1);
                end else begin
                    cyc_n = cyc + CW'(1);
                end
            end
            FR_STOP: begin
                if (!tx_line) begin
                    v_stop = 1'b1;
                    st_n   = FR_IDLE;
                end else if (cyc == CYC_LAST) begin
                    st_n  = FR_GAP;
                    cyc_n = '0;
                end else begin
                    cyc_n = cyc + CW'(1);
                end
            end
            FR_GAP: begin
                v_gap = tx_busy;
                st_n  = FR_IDLE;
            end
            default: st_n = FR_IDLE;
        endcase
    end

    // start-bit low-run measurement, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            run_live <= 1'b0;
            low_run  <= '0;
            meas_len <= '0;
        end else if (st == FR_IDLE && busy_rise) begin
            run_live <= 1'b1;
            low_run  <= '0;
        end else if (run_live) begin
            if (!tx_line) begin
                low_run <= low_run + LEN_W'(1);
                if (low_run == LEN_SAT - LEN_W'(1)) begin
                    run_live <= 1'b0;
                    meas_len <= LEN_SAT;
                end
            end else begin
                run_live <= 1'b0;
                meas_len <= low_run;
            end
        end
    end

    assign v_start = run_live && tx_line && (low_run != LEN_OK);

    // R1: during the start bit the low run equals the cycles elapsed in it
    a_r1_run_tracks_start: assert property (@(posedge clk) disable iff (rst)
        (st == FR_START) |-> (run_live && low_run == LEN_W'(cyc)));

    // R11: the reported length never exceeds the saturation value
    a_r11_len_saturates: assert property (@(posedge clk) disable iff (rst)
        meas_len <= LEN_SAT);

endmodule

// File: rtl/uart_tx_monitor.sv
module uart_tx_monitor
    import uart_mon_pkg::*;
#(
    parameter int BIT_CLKS  = 217,
    parameter int DATA_BITS = 8,
    parameter int HS_WIN    = 10,
    parameter int LEN_W     = $clog2(2 * BIT_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic             tx_ready,
    input  logic             tx_start,
    input  logic             tx_busy,
    input  logic             tx_line,
    output logic [ERR_N-1:0] err_pulse,
    output logic [ERR_N-1:0] err_sticky,
    output logic [LEN_W-1:0] start_len
);
    logic             v_start, v_data, v_stop, v_gap;
    logic             busy_viol, hs_viol;
    logic [ERR_N-1:0] viol;

    uart_mon_frame #(
        .BIT_CLKS (BIT_CLKS),
        .DATA_BITS(DATA_BITS),
        .LEN_W    (LEN_W)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tx_busy (tx_busy),
        .tx_line (tx_line),
        .v_start (v_start),
        .v_data  (v_data),
        .v_stop  (v_stop),
        .v_gap   (v_gap),
        .meas_len(start_len)
    );

    uart_mon_busy u_busy (
        .clk     (clk),
        .rst     (rst),
        .tx_start(tx_start),
        .tx_busy (tx_busy),
        .viol    (busy_viol)
    );

    uart_mon_hshk #(
        .WIN(HS_WIN)
    ) u_hshk (
        .clk     (clk),
        .rst     (rst),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .viol    (hs_viol)
    );

    always_comb begin
        viol          = '0;
        viol[E_START] = v_start;
        viol[E_BUSY]  = busy_viol;
        viol[E_HSHK]  = hs_viol;
        viol[E_STOP]  = v_stop;
        viol[E_DATA]  = v_data;
        viol[E_GAP]   = v_gap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse  <= '0;
            err_sticky <= '0;
        end else begin
            err_pulse  <= viol;
            err_sticky <= err_sticky | viol;
        end
    end

    // R4: a missed busy response reaches the pulse output one cycle later
    a_r4_busy_reported: assert property (@(posedge clk) disable iff (rst)
        busy_viol |=> err_pulse[E_BUSY]);

    // R2: a start-length violation reaches the pulse output one cycle later
    a_r2_start_reported: assert property (@(posedge clk) disable iff (rst)
        v_start |=> err_pulse[E_START]);

    // R9: every pulsing bit is also latched
    a_r9_pulse_latched: assert property (@(posedge clk) disable iff (rst)
        (|err_pulse) |-> ((err_sticky & err_pulse) == err_pulse));

endmodule

// File: tb/uart_tx_monitor_test.sv
module uart_tx_monitor_test;
    localparam int N  = 217;
    localparam int DB = 8;
    localparam int W  = 10;
    localparam int LW = $clog2(2 * N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0, tx_ready = 1'b0, tx_start = 1'b0;
    logic tx_busy = 1'b0, tx_line = 1'b1;
    logic [5:0]    err_pulse, err_sticky;
    logic [LW-1:0] start_len;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;

    typedef struct {
        int         cyc;
        logic [5:0] mask;
        bit         use_len;
        int         len;
        string      req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    uart_tx_monitor #(.BIT_CLKS(N), .DATA_BITS(DB), .HS_WIN(W)) uut (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_start(tx_start), .tx_busy(tx_busy), .tx_line(tx_line),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .start_len(start_len)
    );

    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input int c, input logic [5:0] m, input bit ul,
                        input int l, input string r);
        exp_t e;
        e.cyc = c; e.mask = m; e.use_len = ul; e.len = l; e.req = r;
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // monitor: pop the oldest expectation for each observed pulse
    always @(negedge clk) begin
        ncyc++;
        if (!rst && err_pulse != 6'd0) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected pulse mask", int'(err_pulse), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ncyc != e.cyc || err_pulse != e.mask ||
                    (e.use_len && start_len != LW'(e.len))) begin
                    errors++;
                    $display("FAIL %s actual cyc=%0d mask=%b len=%0d expected cyc=%0d mask=%b len=%0d",
                             e.req, ncyc, err_pulse, start_len, e.cyc, e.mask, e.len);
                end
            end
        end
    end

    // driver: one frame with optional faults; pushes the pulses it expects
    task automatic frame(input logic [7:0] d, input int slen, input int g,
                         input bit stop_lo, input bit keep_busy);
        int t0;
        nxt(); tx_start = 1'b1;
        nxt(); tx_start = 1'b0; tx_busy = 1'b1; t0 = ncyc;
        if (slen < N)
            push(t0 + slen + 2, 6'b000001, 1'b1, slen, "R2 short start");
        else if (slen > N && slen < 2 * N)
            push(t0 + slen + 2, 6'b010001, 1'b1, slen, "R3 long start with R6 change");
        if (g > 0) begin
            push(t0 + g + 1, 6'b010000, 1'b0, 0, "R6 mid-bit change");
            push(t0 + g + 2, 6'b010000, 1'b0, 0, "R6 mid-bit change back");
        end
        if (stop_lo)   push(t0 + 9 * N + 2, 6'b001000, 1'b0, 0, "R7 stop low");
        if (keep_busy) push(t0 + 10 * N + 2, 6'b100000, 1'b0, 0, "R8 no gap");
        for (int o = 1; o <= 10 * N; o++) begin
            logic v;
            if (o <= slen)       v = 1'b0;
            else if (o <= N)     v = 1'b1;
            else if (o <= 9 * N) v = d[(o - N - 1) / N];
            else                 v = 1'b1;
            if (o == g) v = ~v;
            if (stop_lo && o == 9 * N + 1) v = 1'b0;
            nxt(); tx_line = v;
        end
        nxt(); tx_line = 1'b1; tx_busy = keep_busy;
        if (keep_busy) begin
            nxt(); tx_busy = 1'b0;
        end
        repeat (3) nxt();
    endtask

    task automatic hs(input int lat);
        int v;
        nxt(); tx_valid = 1'b1; v = ncyc;
        if (lat == 0) push(v + W + 1, 6'b000100, 1'b0, 0, "R5 handshake timeout");
        for (int j = 1; j <= W + 2; j++) begin
            nxt(); tx_valid = 1'b0; tx_ready = (j == lat);
        end
        nxt(); tx_ready = 1'b0;
        repeat (2) nxt();
    endtask

    initial begin
        int s;
        repeat (4) nxt();
        chk(err_pulse == 6'd0,  "R10 reset pulse",  int'(err_pulse), 0);
        chk(err_sticky == 6'd0, "R10 reset sticky", int'(err_sticky), 0);
        chk(start_len == '0,    "R10 reset length", int'(start_len), 0);
        rst = 1'b0;
        repeat (2) nxt();

        frame(8'hA5, N, 0, 1'b0, 1'b0);
        chk(start_len == LW'(N), "R1 exact start length", int'(start_len), N);
        chk(err_sticky == 6'd0,  "R1 clean frame sticky", int'(err_sticky), 0);

        frame(8'hFF, N - 1, 0, 1'b0, 1'b0);
        chk(err_sticky == 6'b000001, "R2 sticky after short start", int'(err_sticky), 1);

        frame(8'hFF, N + 1, 0, 1'b0, 1'b0);
        chk(start_len == LW'(N + 1), "R3 long start length", int'(start_len), N + 1);

        frame(8'h00, N, 0, 1'b0, 1'b0);
        chk(start_len == LW'(2 * N), "R11 saturated length", int'(start_len), 2 * N);

        frame(8'hFF, N, 4 * N + 50, 1'b0, 1'b0);
        frame(8'hFF, N, 0, 1'b1, 1'b0);
        frame(8'h3C, N, 0, 1'b0, 1'b1);

        // R4: start rise without busy next cycle
        nxt(); tx_start = 1'b1; s = ncyc;
        push(s + 2, 6'b000010, 1'b0, 0, "R4 busy response missing");
        nxt(); tx_start = 1'b0;
        repeat (4) nxt();

        hs(1);
        hs(W);
        hs(0);

        chk(err_sticky == 6'h3F, "R9 all sticky bits", int'(err_sticky), 63);

        // R10: reset abandons a frame in progress
        nxt(); tx_start = 1'b1;
        nxt(); tx_start = 1'b0; tx_busy = 1'b1;
        for (int k = 0; k < 100; k++) begin
            nxt(); tx_line = 1'b0;
        end
        nxt(); rst = 1'b1; tx_busy = 1'b0; tx_line = 1'b1;
        repeat (3) nxt();
        rst = 1'b0;
        nxt(); tx_line = 1'b0;
        nxt(); tx_line = 1'b1;
        repeat (20) nxt();
        chk(err_sticky == 6'd0, "R10 sticky cleared, frame dropped", int'(err_sticky), 0);
        chk(start_len == '0,    "R10 length cleared", int'(start_len), 0);
        chk(q.size() == 0,      "R9 expected pulses all seen", q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule